// File: doc/BRIEF.md
# Glitchless Power-of-Two Clock Prescaler

This block sits between a free-running master clock and an output clock pin. It produces a square wave whose frequency is the master frequency divided by a power of two. The power is taken from a 4-bit exponent. An output-enable input and an active-low power-down input turn the output on and off. Both are synchronized, and every change of state waits for a phase boundary, so the output never shows a shortened high or low phase.

Timing is modelled on a reference clock `clk_i`. The undivided master waveform has one high and one low phase of one reference cycle each, so exponent x gives high and low phases of 2^x reference cycles. A startup hold-off of 512 master periods (1024 reference cycles) follows reset and every exit from power-down. A power-down request must persist for two output periods plus a parameterized deglitch interval before it is honoured. `out_valid_o` is high while the output is being driven. It stands in for the pad leaving high impedance.

Top module: `pow2_clk_prescaler`

## Requirements
- R1: While running with effective exponent x, every high phase and every low phase of `clk_o` lasts exactly 2^x reference cycles (x = 0 toggles every cycle).
- R2: An exponent code above 8 behaves exactly as 8: phases of 256 reference cycles.
- R3: An exponent change takes effect at the next rising edge of `clk_o`. The high phase in progress and the low phase after it keep the old width.
- R4: When the output turns off, the low phase in progress completes in full. Then `clk_o` stays 0 and `out_valid_o` is 0. `clk_o` is never 1 while `out_valid_o` is 0.
- R5: From idle, with the hold-off complete, `oe_i` rising before a reference edge E0 makes `clk_o` rise at edge E0+2 (3 edges counted from E0), for any exponent. The output starts with a full high phase.
- R6: In reset, `clk_o` and `out_valid_o` are 0. With `oe_i` high, the first `clk_o` high follows the 1025th reference edge after reset release.
- R7: `pdn_ni` held low for more than 2^(x+2) + DEGLITCH_CYC cycles (after the 2-stage synchronizer) powers the block down. The output stays off, whatever `oe_i` does, until `pdn_ni` returns high.
- R8: A `pdn_ni` low pulse shorter than 2^(x+2) + DEGLITCH_CYC cycles is ignored, and the output keeps running.
- R9: After `pdn_ni` returns high, with `oe_i` high, the first `clk_o` high follows the 1028th reference edge counted from the edge that first samples `pdn_ni` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock (twice the master rate) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exp_i | input | 4 | Division exponent; codes above 8 saturate |
| oe_i | input | 1 | Output enable, asynchronous, active high |
| pdn_ni | input | 1 | Power-down request, asynchronous, active low |
| clk_o | output | 1 | Divided, gated clock output |
| out_valid_o | output | 1 | High while the output is driven |

## Verification
Three cases are hard to reach from the ports: an exponent change that lands inside a phase, a power-down pulse that stays under the deglitch threshold, and the exact hold-off count after leaving power-down. The stimulus waits on the observed count of rising edges. It then changes the exponent or drops the enable one reference cycle into a known high phase, which places each change at a known point in the waveform. The power-down cases pulse `pdn_ni` once briefly during a running output and once for long while idle with `oe_i` raised. For each case the bench counts reference edges to the first output edge, and a scoreboard checks the width of every high phase.

// File: rtl/pow2_clk_prescaler_pkg.sv
package pow2_clk_prescaler_pkg;
  localparam int unsigned EXP_W = 4;
  typedef logic [EXP_W-1:0] exp_t;

  function automatic exp_t sat_exp(input exp_t e, input int unsigned max_e);
    return (e > exp_t'(max_e)) ? exp_t'(max_e) : e;
  endfunction
endpackage

// File: rtl/pcp_sync.sv
module pcp_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= RST_VAL;
        else         sr_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/pcp_pdn_filter.sv
module pcp_pdn_filter
  import pow2_clk_prescaler_pkg::*;
#(
  parameter int unsigned MAX_EXP      = 8,
  parameter int unsigned DEGLITCH_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pdn_ns_i,
  input  exp_t act_exp_i,
  output logic pd_req_o
);
  localparam int unsigned LIM   = (4 << MAX_EXP) + DEGLITCH_CYC + 1;
  localparam int unsigned CNT_W = $clog2(LIM + 1);

  logic [CNT_W-1:0] low_cnt_q, thr;

  // two output periods (4 half phases) plus deglitch
  assign thr = CNT_W'((32'd4 << act_exp_i) + DEGLITCH_CYC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt_q <= '0;
      pd_req_o  <= 1'b0;
    end else begin
      if (pdn_ns_i)                      low_cnt_q <= '0;
      else if (low_cnt_q != CNT_W'(LIM)) low_cnt_q <= low_cnt_q + 1'b1;
      pd_req_o <= !pdn_ns_i && (low_cnt_q >= thr);
    end
  end

  // R8: no request before the shortest possible threshold has elapsed
  assert_pd_min_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pd_req_o) |-> ($past(low_cnt_q) >= CNT_W'(4 + DEGLITCH_CYC)));
endmodule

// File: rtl/pcp_holdoff.sv
module pcp_holdoff #(
  parameter int unsigned HOLD_TICKS = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_req_i,
  output logic done_o
);
  localparam int unsigned HOLD_W = $clog2(HOLD_TICKS + 1);

  logic [HOLD_W-1:0] cnt_q;

  assign done_o = (cnt_q == HOLD_W'(HOLD_TICKS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (pd_req_i) cnt_q <= '0;
    else if (!done_o)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pcp_divider.sv
module pcp_divider
  import pow2_clk_prescaler_pkg::*;
#(
  parameter int unsigned MAX_EXP = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  exp_t exp_sat_i,
  input  logic want_i,
  output logic q_o,
  output logic run_o,
  output exp_t act_exp_o
);
  localparam int unsigned PH_W = (MAX_EXP > 0) ? MAX_EXP : 1;

  logic [PH_W-1:0] ph_q, half_m1;
  logic            q_q, run_q;
  exp_t            act_q;

  assign half_m1 = PH_W'((32'd1 << act_q) - 32'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= '0;
      q_q   <= 1'b0;
      run_q <= 1'b0;
      act_q <= '0;
    end else if (!run_q) begin
      act_q <= exp_sat_i;
      ph_q  <= '0;
      if (want_i) begin
        run_q <= 1'b1;
        q_q   <= 1'b1;
      end
    end else if (ph_q != half_m1) begin
      ph_q <= ph_q + 1'b1;
    end else begin
      ph_q <= '0;
      if (q_q) begin
        q_q <= 1'b0;
      end else if (want_i) begin
        q_q   <= 1'b1;
        act_q <= exp_sat_i;          // ratio change only at a rising edge
      end else begin
        run_q <= 1'b0;               // stop after a full low phase
      end
    end
  end

  assign q_o       = q_q;
  assign run_o     = run_q;
  assign act_exp_o = act_q;

  // check-only phase length tracker
  logic            q_d;
  logic [PH_W:0]   len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_d   <= 1'b0;
      len_q <= '0;
    end else begin
      q_d <= q_q;
      if (q_d != q_q)   len_q <= (PH_W+1)'(1);
      else if (~&len_q) len_q <= len_q + 1'b1;
    end
  end

  assert_phase_width_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(run_q) && (q_q != q_d)) |-> (len_q == (PH_W+1)'(32'd1 << $past(act_q))));

  assert_exp_at_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(run_q) && (act_q != $past(act_q))) |-> (q_q && !$past(q_q)));

  assert_exp_sat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q <= exp_t'(MAX_EXP));
endmodule

// File: rtl/pow2_clk_prescaler.sv
module pow2_clk_prescaler
  import pow2_clk_prescaler_pkg::*;
#(
  parameter int unsigned MAX_EXP      = 8,
  parameter int unsigned HOLD_CYC     = 512,
  parameter int unsigned DEGLITCH_CYC = 16,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] exp_i,
  input  logic       oe_i,
  input  logic       pdn_ni,
  output logic       clk_o,
  output logic       out_valid_o
);
  localparam int unsigned HOLD_TICKS = 2 * HOLD_CYC;

  logic oe_s, pdn_ns, pd_req, hold_done, want;
  exp_t act_exp;

  pcp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_oe_sync (
    .clk_i, .rst_ni, .d_i(oe_i), .q_o(oe_s));

  pcp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pdn_sync (
    .clk_i, .rst_ni, .d_i(pdn_ni), .q_o(pdn_ns));

  pcp_pdn_filter #(.MAX_EXP(MAX_EXP), .DEGLITCH_CYC(DEGLITCH_CYC)) u_filter (
    .clk_i, .rst_ni, .pdn_ns_i(pdn_ns), .act_exp_i(act_exp), .pd_req_o(pd_req));

  pcp_holdoff #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk_i, .rst_ni, .pd_req_i(pd_req), .done_o(hold_done));

  assign want = oe_s && !pd_req && hold_done;

  pcp_divider #(.MAX_EXP(MAX_EXP)) u_div (
    .clk_i, .rst_ni,
    .exp_sat_i(sat_exp(exp_i, MAX_EXP)),
    .want_i(want),
    .q_o(clk_o),
    .run_o(out_valid_o),
    .act_exp_o(act_exp));

  assert_off_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> !clk_o);

  // R6 and R9: output may only start once the hold-off has elapsed
  assert_start_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> ($past(hold_done) && !$past(pd_req)));

  assert_start_oe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> ($past(oe_s) && clk_o));

  assert_pd_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_req && !out_valid_o) |=> !out_valid_o);
endmodule

// File: tb/pow2_clk_prescaler_tb_top.sv
module pow2_clk_prescaler_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] exp_v = 4'd2;
  logic       oe = 1'b1;
  logic       pdn_n = 1'b1;
  logic       clk_o, out_valid;

  always #5 clk = ~clk;

  pow2_clk_prescaler dut_i (
    .clk_i(clk), .rst_ni(rst_n), .exp_i(exp_v), .oe_i(oe), .pdn_ni(pdn_n),
    .clk_o(clk_o), .out_valid_o(out_valid));

  typedef struct { int w; string tag; } exp_item_t;
  exp_item_t sb_q[$];
  exp_item_t it;

  int vectors = 0, miscompares = 0;
  int rise_cnt = 0, hi_len = 0;
  bit prev_o = 1'b0, finished = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic push_w(input int n, input int w, input string tag);
    for (int i = 0; i < n; i++) sb_q.push_back('{w: w, tag: tag});
  endtask

  // monitor: measure every high phase and compare against the scoreboard
  always @(negedge clk) begin
    if (clk_o) begin
      if (!prev_o) begin rise_cnt++; hi_len = 1; end
      else hi_len++;
    end else if (prev_o) begin
      if (sb_q.size() == 0) check(1'b0, "R1", "unexpected high phase", hi_len, 0);
      else begin
        it = sb_q.pop_front();
        check(hi_len == it.w, it.tag, "high phase width", hi_len, it.w);
      end
    end
    prev_o = clk_o;
  end

  task automatic edges_to_high(output int n);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!clk_o && n < 5000);
  endtask

  task automatic stop_at(input int target);
    wait (rise_cnt == target);
    @(negedge clk); oe = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0, r0;
    bit bad = 1'b0;
    while (out_valid && n < 2000) begin @(negedge clk); n++; end
    check(!out_valid, "R4", "output turned off", out_valid, 0);
    r0 = rise_cnt;
    repeat (20) begin @(negedge clk); if (clk_o || out_valid) bad = 1'b1; end
    check(!bad && rise_cnt == r0, "R4", "idle output quiet", rise_cnt - r0, 0);
  endtask

  initial begin
    int n, base;
    bit bad;
    // R6: reset state and hold-off
    push_w(3, 4, "R1");
    repeat (5) @(negedge clk);
    check(clk_o == 1'b0, "R6", "clk_o in reset", clk_o, 0);
    check(out_valid == 1'b0, "R6", "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    edges_to_high(n);
    check(n == 1025, "R6", "edges to first high after reset", n, 1025);
    check(out_valid == 1'b1, "R6", "valid with first high", out_valid, 1);
    stop_at(3);
    wait_idle();

    // R5: fixed enable latency, exponent 5
    exp_v = 4'd5; base = rise_cnt;
    push_w(2, 32, "R1");
    @(negedge clk); oe = 1'b1;
    edges_to_high(n);
    check(n == 3, "R5", "enable latency x=5", n, 3);
    stop_at(base + 2);
    wait_idle();

    // R5 at x=0, then R3: switch 0 -> 2 after the first high
    exp_v = 4'd0; base = rise_cnt;
    push_w(1, 1, "R1"); push_w(3, 4, "R3");
    @(negedge clk); oe = 1'b1;
    edges_to_high(n);
    check(n == 3, "R5", "enable latency x=0", n, 3);
    wait (rise_cnt == base + 1);
    @(negedge clk); exp_v = 4'd2;
    stop_at(base + 4);
    wait_idle();

    // R3: change 3 -> 4 inside a high phase
    exp_v = 4'd3; base = rise_cnt;
    push_w(2, 8, "R3"); push_w(2, 16, "R3");
    @(negedge clk); oe = 1'b1;
    wait (rise_cnt == base + 2);
    @(negedge clk); exp_v = 4'd4;
    stop_at(base + 4);
    wait_idle();

    // R2: codes above 8 saturate
    exp_v = 4'd13; base = rise_cnt;
    push_w(2, 256, "R2");
    @(negedge clk); oe = 1'b1;
    stop_at(base + 2);
    wait_idle();
    exp_v = 4'd15; base = rise_cnt;
    push_w(1, 256, "R2");
    @(negedge clk); oe = 1'b1;
    stop_at(base + 1);
    wait_idle();

    // R8: short power-down pulse ignored
    exp_v = 4'd2; base = rise_cnt;
    push_w(20, 4, "R8");
    @(negedge clk); oe = 1'b1;
    wait (rise_cnt == base + 2);
    @(negedge clk); pdn_n = 1'b0;
    bad = 1'b0;
    repeat (10) begin @(negedge clk); if (!out_valid) bad = 1'b1; end
    pdn_n = 1'b1;
    repeat (60) begin @(negedge clk); if (!out_valid) bad = 1'b1; end
    check(!bad, "R8", "output kept running through short pulse", bad, 0);
    stop_at(base + 20);
    wait_idle();

    // R7: long power-down holds output off; R9: restart hold-off
    @(negedge clk); pdn_n = 1'b0;
    repeat (100) @(negedge clk);
    oe = 1'b1;
    bad = 1'b0;
    repeat (100) begin @(negedge clk); if (out_valid || clk_o) bad = 1'b1; end
    check(!bad, "R7", "output off during power-down", bad, 0);
    base = rise_cnt;
    push_w(2, 4, "R9");
    pdn_n = 1'b1;
    edges_to_high(n);
    check(n == 1028, "R9", "edges to first high after power-down", n, 1028);
    stop_at(base + 2);
    wait_idle();

    check(sb_q.size() == 0, "R1", "expected phases left", sb_q.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      vectors++; miscompares++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule